// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block watches the command side of a DDR2-style memory bus from the memory's point of view. On every rising clock edge where clock enable is high, it samples chip select, the three command strobes, the bank address and the row/column address. It turns them into a command and updates a table that records, for each bank, whether a row is open and which row it is. A command that the bank state does not allow is flagged with a one-cycle error pulse and has no other effect.

The same decoder holds the four mode registers written by the load-mode command. It reports the CAS latency, the additive latency, the read latency (their sum), the write latency (one less than read latency) and the burst length. These values also set how long a read or write with auto-precharge keeps its bank open. When clock enable is sampled low, the block stops decoding and reports which low-power state the bus has entered.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: After reset all banks are closed, every stored row is 0, the error output is low, the power state is 0, and the mode outputs read CAS latency 3, additive latency 0, read latency 3, write latency 2, burst length 4 (register 0 resets to 0x032, the others to 0).
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 load mode, 0111 and 0110 no-op. With cs_n high, nothing changes. An activate to a closed bank opens it and stores addr as that bank's row in open_rows[b*ROW_W +: ROW_W].
- R3: An activate to an open bank, or a read or write to a closed bank, sets cmd_err high for exactly the cycle after that edge. Bank states and rows stay as they were.
- R4: A precharge with addr[10] low closes only the bank named by ba. With addr[10] high it closes every bank. A precharge never raises an error and cancels any pending auto-precharge on the banks it closes.
- R5: A legal read or write with addr[10] high leaves its bank open and closes it N edges after the command edge. N is read latency + burst/2 for a read and write latency + burst/2 for a write, using the mode values in force at the command. With addr[10] low the bank stays open.
- R6: A refresh with every bank closed changes nothing and raises no error. A refresh with any bank open raises the error pulse.
- R7: A load mode writes addr into mode register ba[1:0]. Register 0 holds burst length in bits 2:0 (2 means 4, 3 means 8) and CAS latency in bits 6:4. Register 1 holds additive latency in bits 5:3. rd_lat equals cas_lat + add_lat and wr_lat equals rd_lat - 1. All four registers appear in mode_regs[i*ROW_W +: ROW_W].
- R8: A load mode to register 0 with CAS latency outside 3..5 or a burst code other than 2 or 3, or to register 1 with additive latency above 4, raises the error pulse and leaves the register unchanged.
- R9: An edge with cke low decodes no command and raises no error. pd_mode then reads 1 for precharge power-down (all banks closed), 2 for active power-down (any bank open), or 3 for self refresh (a refresh command on the entry edge with all banks closed). Entry is judged at the first low edge, the state is held while cke stays low, and it returns to 0 at the next edge with cke high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode register select |
| addr | input | 14 | Row, column and auto-precharge bit, or mode opcode |
| bank_open | output | 8 | One bit per bank, high when a row is open |
| open_rows | output | 112 | Stored row per bank |
| cmd_err | output | 1 | One-cycle illegal command pulse |
| cas_lat | output | 3 | CAS latency |
| add_lat | output | 3 | Additive latency |
| rd_lat | output | 4 | Read latency |
| wr_lat | output | 4 | Write latency |
| burst_len | output | 4 | Burst length, 4 or 8 |
| mode_regs | output | 56 | The four mode registers side by side |
| pd_mode | output | 2 | Low-power state |

## Verification
The bench builds the block with its default eight banks, 14-bit addresses and four mode registers, so that a bank-select or mode-select value of any width is legal and both A10 meanings can be reached. With eight banks, random traffic often hits an open bank with an activate and a closed bank with a read. Legal load-mode values move read latency between 3 and 9, so the auto-precharge close time ranges from 4 to 13 edges and can meet a later command to the same bank while the close is still pending.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  localparam int AP_BIT = 10;   // auto-precharge / all-bank select
  localparam int BL_LSB = 0;    // register 0
  localparam int CL_LSB = 4;    // register 0
  localparam int AL_LSB = 3;    // register 1
  localparam int FLD_W  = 3;

  localparam logic [1:0] PD_NONE = 2'd0;
  localparam logic [1:0] PD_PRE  = 2'd1;
  localparam logic [1:0] PD_ACT  = 2'd2;
  localparam logic [1:0] PD_SELF = 2'd3;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_LMR;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic cl_legal(input logic [FLD_W-1:0] cl);
    return (cl >= 3'd3) && (cl <= 3'd5);
  endfunction

  function automatic logic bl_legal(input logic [FLD_W-1:0] bl);
    return (bl == 3'd2) || (bl == 3'd3);
  endfunction

  function automatic logic al_legal(input logic [FLD_W-1:0] al);
    return al <= 3'd4;
  endfunction

  function automatic logic [3:0] beats_of(input logic [FLD_W-1:0] bl);
    return (bl == 3'd3) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [3:0] read_lat(input logic [FLD_W-1:0] cl,
                                          input logic [FLD_W-1:0] al);
    return {1'b0, cl} + {1'b0, al};
  endfunction

  function automatic logic [3:0] write_lat(input logic [3:0] rl);
    return rl - 4'd1;
  endfunction

  function automatic logic [4:0] close_delay(input logic [3:0] lat,
                                             input logic [3:0] beats);
    return {1'b0, lat} + {2'b00, beats[3:1]};
  endfunction

endpackage

// File: rtl/ddr2_mode_regs.sv
module ddr2_mode_regs
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_MR = 4,
  parameter int MR_W   = 14,
  localparam int SEL_W = $clog2(NUM_MR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_go,
  input  logic [SEL_W-1:0]       ld_sel,
  input  logic [MR_W-1:0]        ld_data,
  output logic                   ld_bad,
  output logic [NUM_MR*MR_W-1:0] mode_flat,
  output logic [2:0]             cas_lat,
  output logic [2:0]             add_lat,
  output logic [3:0]             rd_lat,
  output logic [3:0]             wr_lat,
  output logic [3:0]             burst_len
);

  localparam logic [MR_W-1:0] MR0_RST = MR_W'(7'h32);

  logic [MR_W-1:0] mr_q [NUM_MR];

  always_comb begin
    ld_bad = 1'b0;
    if (ld_sel == SEL_W'(0))
      ld_bad = !(cl_legal(ld_data[CL_LSB +: FLD_W]) && bl_legal(ld_data[BL_LSB +: FLD_W]));
    else if (ld_sel == SEL_W'(1))
      ld_bad = !al_legal(ld_data[AL_LSB +: FLD_W]);
  end

  for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
    always_ff @(posedge clk) begin
      if (!rst_n)
        mr_q[i] <= (i == 0) ? MR0_RST : '0;
      else if (ld_go && !ld_bad && (ld_sel == SEL_W'(i)))
        mr_q[i] <= ld_data;
    end
    assign mode_flat[i*MR_W +: MR_W] = mr_q[i];
  end

  assign cas_lat   = mr_q[0][CL_LSB +: FLD_W];
  assign add_lat   = mr_q[1][AL_LSB +: FLD_W];
  assign rd_lat    = read_lat(cas_lat, add_lat);
  assign wr_lat    = write_lat(rd_lat);
  assign burst_len = beats_of(mr_q[0][BL_LSB +: FLD_W]);

endmodule

// File: rtl/ddr2_bank_table.sv
module ddr2_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 5,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_go,
  input  logic                       pre_go,
  input  logic                       pre_all,
  input  logic                       ap_go,
  input  logic [BA_W-1:0]            bank_sel,
  input  logic [ROW_W-1:0]           row_in,
  input  logic [CNT_W-1:0]           ap_delay,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] row_flat,
  output logic [NUM_BANKS-1:0]       expire
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;

    assign hit = (bank_sel == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
        cnt_q  <= '0;
      end else if (pre_go && (pre_all || hit)) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else if (act_go && hit) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end else if (ap_go && hit) begin
        cnt_q  <= ap_delay;
      end else if (cnt_q == CNT_W'(1)) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - CNT_W'(1);
      end
    end

    assign bank_open[b]               = open_q;
    assign row_flat[b*ROW_W +: ROW_W] = row_q;
    assign expire[b]                  = (cnt_q == CNT_W'(1));
  end

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int NUM_MR    = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int SEL_W    = $clog2(NUM_MR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       cmd_err,
  output logic [2:0]                 cas_lat,
  output logic [2:0]                 add_lat,
  output logic [3:0]                 rd_lat,
  output logic [3:0]                 wr_lat,
  output logic [3:0]                 burst_len,
  output logic [NUM_MR*ROW_W-1:0]    mode_regs,
  output logic [1:0]                 pd_mode
);

  localparam int CNT_W = 5;

  cmd_e             cmd_w;
  logic             tgt_open;
  logic             any_open;
  logic             act_go, act_bad;
  logic             rw_cmd, rw_bad, ap_go;
  logic             pre_go, ref_bad;
  logic             ld_go, ld_bad, lmr_bad;
  logic             illegal_w;
  logic [CNT_W-1:0] ap_delay;
  logic [NUM_BANKS-1:0] bank_expire;

  assign cmd_w    = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign tgt_open = bank_open[ba];
  assign any_open = |bank_open;

  assign act_go   = cke && (cmd_w == CMD_ACT) && !tgt_open;
  assign act_bad  = cke && (cmd_w == CMD_ACT) && tgt_open;
  assign rw_cmd   = cke && ((cmd_w == CMD_RD) || (cmd_w == CMD_WR));
  assign rw_bad   = rw_cmd && !tgt_open;
  assign ap_go    = rw_cmd && tgt_open && addr[AP_BIT];
  assign pre_go   = cke && (cmd_w == CMD_PRE);
  assign ref_bad  = cke && (cmd_w == CMD_REF) && any_open;
  assign ld_go    = cke && (cmd_w == CMD_LMR);
  assign lmr_bad  = ld_go && ld_bad;
  assign illegal_w = act_bad || rw_bad || ref_bad || lmr_bad;

  assign ap_delay = CNT_W'(close_delay((cmd_w == CMD_WR) ? wr_lat : rd_lat, burst_len));

  ddr2_mode_regs #(.NUM_MR(NUM_MR), .MR_W(ROW_W)) mode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_go     (ld_go),
    .ld_sel    (ba[SEL_W-1:0]),
    .ld_data   (addr),
    .ld_bad    (ld_bad),
    .mode_flat (mode_regs),
    .cas_lat   (cas_lat),
    .add_lat   (add_lat),
    .rd_lat    (rd_lat),
    .wr_lat    (wr_lat),
    .burst_len (burst_len)
  );

  ddr2_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_go    (act_go),
    .pre_go    (pre_go),
    .pre_all   (addr[AP_BIT]),
    .ap_go     (ap_go),
    .bank_sel  (ba),
    .row_in    (addr),
    .ap_delay  (ap_delay),
    .bank_open (bank_open),
    .row_flat  (open_rows),
    .expire    (bank_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_err <= 1'b0;
      pd_mode <= PD_NONE;
    end else begin
      cmd_err <= illegal_w;
      if (cke)
        pd_mode <= PD_NONE;
      else if (pd_mode == PD_NONE) begin
        if (any_open)               pd_mode <= PD_ACT;
        else if (cmd_w == CMD_REF)  pd_mode <= PD_SELF;
        else                        pd_mode <= PD_PRE;
      end
    end
  end

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cke,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic                       a10,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] open_rows,
  input logic                       cmd_err,
  input logic [2:0]                 cas_lat,
  input logic [2:0]                 add_lat,
  input logic [3:0]                 burst_len,
  input logic [1:0]                 pd_mode,
  input logic [NUM_BANKS-1:0]       expire
);

  AST_DESEL_ROWS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> $stable(open_rows)); // R2

  AST_DESEL_BANKS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && (expire == '0)) |=> $stable(bank_open)); // R2

  AST_ERR_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(open_rows)); // R3

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && cas_n && !we_n && a10) |=> (bank_open == '0)); // R4

  AST_REF_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && !cas_n && we_n && (bank_open != '0)) |=> cmd_err); // R6

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= 3'd3) && (cas_lat <= 3'd5) && (add_lat <= 3'd4) &&
    ((burst_len == 4'd4) || (burst_len == 4'd8))); // R8

  AST_PD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode != 2'd0) |-> !cmd_err); // R9

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .a10       (addr[10]),
  .bank_open (bank_open),
  .open_rows (open_rows),
  .cmd_err   (cmd_err),
  .cas_lat   (cas_lat),
  .add_lat   (add_lat),
  .burst_len (burst_len),
  .pd_mode   (pd_mode),
  .expire    (bank_expire)
);

// File: tb/ddr2_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker_tb_top;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_LMR = 3'b000,
                         C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [2:0]   ba;
  logic [13:0]  addr;
  logic [7:0]   bank_open;
  logic [111:0] open_rows;
  logic         cmd_err;
  logic [2:0]   cas_lat, add_lat;
  logic [3:0]   rd_lat, wr_lat, burst_len;
  logic [55:0]  mode_regs;
  logic [1:0]   pd_mode;

  always #2.5 clk = ~clk;

  ddr2_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_rows(open_rows), .cmd_err(cmd_err),
    .cas_lat(cas_lat), .add_lat(add_lat), .rd_lat(rd_lat), .wr_lat(wr_lat),
    .burst_len(burst_len), .mode_regs(mode_regs), .pd_mode(pd_mode)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference model state
  bit          m_open [8];
  logic [13:0] m_row  [8];
  int          m_cnt  [8];
  logic [13:0] m_mr   [4];
  int          m_pd;
  bit          m_err;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_rl();
    return int'(m_mr[0][6:4]) + int'(m_mr[1][5:3]);
  endfunction

  function automatic int m_beats();
    return (m_mr[0][2:0] == 3'd3) ? 8 : 4;
  endfunction

  function automatic logic [7:0] exp_open();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_open[i];
    return v;
  endfunction

  function automatic logic [111:0] exp_rows();
    logic [111:0] v;
    for (int i = 0; i < 8; i++) v[i*14 +: 14] = m_row[i];
    return v;
  endfunction

  function automatic logic [55:0] exp_mr();
    logic [55:0] v;
    for (int i = 0; i < 4; i++) v[i*14 +: 14] = m_mr[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = '0; m_cnt[i] = 0; end
    m_mr[0] = 14'h032; m_mr[1] = '0; m_mr[2] = '0; m_mr[3] = '0;
    m_pd = 0; m_err = 0;
  endtask

  task automatic model_step();
    bit any = 0;
    bit err = 0;
    bit preh [8];
    bit acth [8];
    bit aph  [8];
    int load = 0;
    logic [2:0] rcw = {ras_n, cas_n, we_n};
    for (int i = 0; i < 8; i++) begin any |= m_open[i]; preh[i] = 0; acth[i] = 0; aph[i] = 0; end
    if (!cke) begin
      if (m_pd == 0) m_pd = any ? 2 : ((!cs_n && rcw == C_REF) ? 3 : 1);
    end else begin
      m_pd = 0;
    end
    if (cke && !cs_n) begin
      case (rcw)
        C_ACT: if (m_open[ba]) err = 1; else acth[ba] = 1;
        C_RD, C_WR: begin
          if (!m_open[ba]) err = 1;
          else if (addr[10]) begin
            aph[ba] = 1;
            load = ((rcw == C_RD) ? m_rl() : m_rl() - 1) + m_beats() / 2;
          end
        end
        C_PRE: for (int i = 0; i < 8; i++) if (addr[10] || i == int'(ba)) preh[i] = 1;
        C_REF: if (any) err = 1;
        C_LMR: begin
          bit bad = 0;
          if (ba[1:0] == 2'd0)
            bad = !((addr[6:4] >= 3 && addr[6:4] <= 5) && (addr[2:0] == 2 || addr[2:0] == 3));
          else if (ba[1:0] == 2'd1)
            bad = addr[5:3] > 4;
          if (bad) err = 1; else m_mr[ba[1:0]] = addr;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 8; i++) begin
      if (preh[i]) begin m_open[i] = 0; m_cnt[i] = 0; end
      else if (acth[i]) begin m_open[i] = 1; m_row[i] = addr; end
      else if (aph[i]) m_cnt[i] = load;
      else if (m_cnt[i] == 1) begin m_open[i] = 0; m_cnt[i] = 0; end
      else if (m_cnt[i] > 0) m_cnt[i]--;
    end
    m_err = err;
  endtask

  task automatic compare_all();
    check("R2 bank_open", bank_open, exp_open());
    check("R2 open_rows", open_rows, exp_rows());
    check("R3 cmd_err", cmd_err, m_err);
    check("R7 latencies", {cas_lat, add_lat, rd_lat, wr_lat, burst_len},
          {m_mr[0][6:4], m_mr[1][5:3], 4'(m_rl()), 4'(m_rl() - 1), 4'(m_beats())});
    check("R7 mode_regs", mode_regs, exp_mr());
    check("R9 pd_mode", pd_mode, m_pd);
  endtask

  // drive at a falling edge, step the model, check after the next rising edge
  task automatic drive(input bit c_cke, input bit c_cs, input logic [2:0] rcw,
                       input logic [2:0] b, input logic [13:0] a);
    cke = c_cke; cs_n = c_cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic nop();
    drive(1, 0, C_NOP, 3'd0, 14'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = C_NOP; ba = '0; addr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 banks closed", bank_open, 8'h00);
    check("R1 rows zero", open_rows, '0);
    check("R1 no error", cmd_err, 1'b0);
    check("R1 latencies", {cas_lat, add_lat, rd_lat, wr_lat, burst_len}, {3'd3, 3'd0, 4'd3, 4'd2, 4'd4});
    check("R1 pd_mode", pd_mode, 2'd0);
    check("R1 mode_regs", mode_regs, 56'h32);

    // R2 activate, chip select masking
    drive(1, 0, C_ACT, 3'd3, 14'h1ABC);
    check("R2 act opens bank 3", bank_open, 8'h08);
    check("R2 row stored", open_rows[3*14 +: 14], 14'h1ABC);
    drive(1, 1, C_ACT, 3'd3, 14'h0123);
    check("R2 deselect ignored", {cmd_err, open_rows[3*14 +: 14]}, {1'b0, 14'h1ABC});
    // R3 illegal commands
    drive(1, 0, C_ACT, 3'd3, 14'h0555);
    check("R3 act to open bank err", {cmd_err, open_rows[3*14 +: 14]}, {1'b1, 14'h1ABC});
    nop();
    check("R3 err is one cycle", cmd_err, 1'b0);
    drive(1, 0, C_RD, 3'd5, 14'h0000);
    check("R3 read closed bank err", {cmd_err, bank_open}, {1'b1, 8'h08});
    // R4 precharge single / all
    drive(1, 0, C_ACT, 3'd5, 14'h0005);
    drive(1, 0, C_PRE, 3'd3, 14'h0000);
    check("R4 single precharge", bank_open, 8'h20);
    drive(1, 0, C_ACT, 3'd0, 14'h0077);
    drive(1, 0, C_PRE, 3'd6, 14'h0400);
    check("R4 all-bank precharge", bank_open, 8'h00);
    // R6 refresh
    drive(1, 0, C_REF, 3'd0, 14'h0000);
    check("R6 idle refresh ok", cmd_err, 1'b0);
    drive(1, 0, C_ACT, 3'd2, 14'h0002);
    drive(1, 0, C_REF, 3'd0, 14'h0000);
    check("R6 busy refresh err", {cmd_err, bank_open}, {1'b1, 8'h04});
    drive(1, 0, C_PRE, 3'd0, 14'h0400);
    // R5 auto-precharge read: 3 + 4/2 = 5 edges
    drive(1, 0, C_ACT, 3'd1, 14'h0011);
    drive(1, 0, C_RD, 3'd1, 14'h0400);
    repeat (4) nop();
    check("R5 read ap still open", bank_open, 8'h02);
    nop();
    check("R5 read ap closed", bank_open, 8'h00);
    // R5 auto-precharge write: 2 + 2 = 4 edges
    drive(1, 0, C_ACT, 3'd1, 14'h0012);
    drive(1, 0, C_WR, 3'd1, 14'h0400);
    repeat (3) nop();
    check("R5 write ap still open", bank_open, 8'h02);
    nop();
    check("R5 write ap closed", bank_open, 8'h00);
    drive(1, 0, C_ACT, 3'd7, 14'h0013);
    drive(1, 0, C_RD, 3'd7, 14'h0000);
    repeat (8) nop();
    check("R5 plain read keeps open", bank_open, 8'h80);
    drive(1, 0, C_PRE, 3'd7, 14'h0000);
    // R7 mode loads
    drive(1, 0, C_LMR, 3'd0, 14'h0053);
    check("R7 CL5 BL8", {cas_lat, rd_lat, wr_lat, burst_len}, {3'd5, 4'd5, 4'd4, 4'd8});
    drive(1, 0, C_LMR, 3'd1, 14'h0010);
    check("R7 AL2", {add_lat, rd_lat, wr_lat}, {3'd2, 4'd7, 4'd6});
    drive(1, 0, C_LMR, 3'd2, 14'h0155);
    check("R7 register 2", mode_regs[2*14 +: 14], 14'h0155);
    drive(1, 0, C_LMR, 3'd3, 14'h2AAA);
    check("R7 register 3", mode_regs[3*14 +: 14], 14'h2AAA);
    // R8 illegal loads
    drive(1, 0, C_LMR, 3'd0, 14'h0063);
    check("R8 CL6 rejected", {cmd_err, cas_lat}, {1'b1, 3'd5});
    drive(1, 0, C_LMR, 3'd0, 14'h0031);
    check("R8 BL code 1 rejected", {cmd_err, burst_len}, {1'b1, 4'd8});
    drive(1, 0, C_LMR, 3'd1, 14'h0028);
    check("R8 AL5 rejected", {cmd_err, add_lat}, {1'b1, 3'd2});
    // R9 power states
    drive(0, 0, C_ACT, 3'd1, 14'h0001);
    check("R9 precharge pd, act ignored", {pd_mode, bank_open, cmd_err}, {2'd1, 8'h00, 1'b0});
    drive(0, 0, C_REF, 3'd0, 14'h0000);
    check("R9 state held", pd_mode, 2'd1);
    nop();
    check("R9 exit", pd_mode, 2'd0);
    drive(1, 0, C_ACT, 3'd4, 14'h0044);
    drive(0, 0, C_RD, 3'd6, 14'h0000);
    check("R9 active pd, read ignored", {pd_mode, cmd_err}, {2'd2, 1'b0});
    drive(1, 0, C_PRE, 3'd0, 14'h0400);
    drive(0, 0, C_REF, 3'd0, 14'h0000);
    check("R9 self refresh", pd_mode, 2'd3);
    nop();

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int p = $urandom_range(0, 19);
      bit k = ($urandom_range(0, 99) >= 4);
      logic [2:0]  b = 3'($urandom_range(0, 7));
      logic [13:0] a = 14'($urandom);
      logic [2:0]  rcw;
      bit c = 0;
      if (p <= 5) rcw = C_ACT;
      else if (p <= 8) rcw = C_RD;
      else if (p <= 11) rcw = C_WR;
      else if (p <= 13) begin rcw = C_PRE; a[10] = ($urandom_range(0, 9) < 3); end
      else if (p == 14) rcw = C_REF;
      else if (p == 15) begin
        rcw = C_LMR;
        a[6:4] = 3'($urandom_range(2, 6));
        a[2:0] = 3'($urandom_range(1, 4));
        if (b[1:0] == 2'd1) a[5:3] = 3'($urandom_range(0, 5));
      end
      else if (p <= 17) rcw = C_NOP;
      else begin rcw = 3'($urandom_range(0, 7)); c = 1; end
      drive(k, c, rcw, b, a);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule